// File: doc/BRIEF.md
# Big-Integer Limb Multiply-Accumulate Chain

This unit multiplies an unsigned big integer, held as a sequence of 64-bit limbs, by one 64-bit scalar. Limbs arrive one at a time, least significant first, on a valid/ready input stream. For each limb the unit forms the exact 128-bit value limb × scalar + carry. The lower 64 bits leave on a valid/ready output stream as the result limb for that position. The upper 64 bits are written to a dedicated carry register, and that register is the addend for the next limb.

A run begins with a one-cycle start pulse. The pulse captures the scalar, the limb count and an initial carry. The initial carry is zero for a fresh product. For a resumed run it is the carry-out of an earlier partial run: because the carry register is the only state carried between limbs, a long product can be split into pieces. When the last output limb is accepted, the carry register holds the most significant limb of the product. That value is shown on a carry-out port, and a done flag pulses for one cycle.

Top module: `limb_mac_chain`

## Requirements
- R1: Each output limb equals the low 64 bits of (input limb × scalar + current carry), with all three operands taken as unsigned.
- R2: When an output limb is accepted, the carry register takes the high 64 bits of that limb's 128-bit sum. After a run, carry_o is the most significant limb of the product.
- R3: A start pulse accepted while idle loads the carry register from carry_in_i. A zero value starts a fresh product, and a nonzero value continues an earlier partial run, so that two split runs give the same limbs and final carry as one run.
- R4: Limbs are taken and produced least significant first. Exactly count_i input limbs are taken and count_i output limbs are produced, and then the unit returns to idle with in_ready_o and out_valid_o low.
- R5: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_limb_o does not change.
- R6: carry_o changes only when an output limb is accepted or when a start is taken while idle.
- R7: done_o is high for exactly one cycle, the cycle after the final output limb is accepted.
- R8: A start pulse during a run has no effect: the scalar, the count and the carry of the run in progress are kept.
- R9: A start with count_i equal to 0 takes no limbs, loads carry_o from carry_in_i and raises done_o in the next cycle.
- R10: in_ready_o is high only while a limb is awaited and is never high together with out_valid_o. After reset, in_ready_o, out_valid_o and done_o are 0 and carry_o is 0.
- R11: All-ones operands cannot overflow. A limb, scalar and carry of 2^64−1 give a result limb of 0 and a carry of 2^64−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a run when the unit is idle |
| scalar_i | input | W | Scalar multiplier, captured at start |
| count_i | input | CNT_W | Number of limbs in the run, captured at start |
| carry_in_i | input | W | Initial carry, captured at start |
| in_valid_i | input | 1 | Input limb valid |
| in_limb_i | input | W | Input limb |
| in_ready_o | output | 1 | Unit is waiting for an input limb |
| out_valid_o | output | 1 | Output limb valid |
| out_limb_o | output | W | Output limb (low half of the step result) |
| out_ready_i | input | 1 | Consumer accepts the output limb |
| carry_o | output | W | Carry register; the final most significant limb after a run |
| done_o | output | 1 | One-cycle pulse after the final output limb is accepted |

## Verification
Two conditions are hard to reach from the ports. The first is a start pulse that arrives during a run. The bench raises start with a different scalar and count while an output limb is held back by out_ready_i low, then lets the run finish and compares every limb with the original operands. The second is resuming from a saved carry. A four-limb product is computed once in a single run and once as two two-limb runs, where the second run is seeded with the first run's carry_o, and the two final carries must agree. All-ones operands drive the step sum to its largest value.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAKE = 2'd1,
        ST_GIVE = 2'd2
    } lmc_state_e;
endpackage

// File: rtl/lmc_muladd.sv
module lmc_muladd #(
    parameter int W = 64
) (
    input  logic [W-1:0] mul_a,
    input  logic [W-1:0] mul_b,
    input  logic [W-1:0] add_c,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi
);
    localparam int RW = 2 * W;

    logic [RW-1:0] wide;

    // (2^W-1)^2 + (2^W-1) < 2^(2W): the sum always fits in RW bits
    assign wide   = {{W{1'b0}}, mul_a} * {{W{1'b0}}, mul_b} + {{W{1'b0}}, add_c};
    assign res_lo = wide[W-1:0];
    assign res_hi = wide[RW-1:W];
endmodule

// File: rtl/lmc_seq.sv
module lmc_seq
    import lmc_pkg::*;
#(
    parameter int W     = 64,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W-1:0]     scalar_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [W-1:0]     carry_in_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    input  logic [W-1:0]     prod_lo_i,
    input  logic [W-1:0]     prod_hi_i,
    output logic [W-1:0]     out_limb_o,
    output logic [W-1:0]     scalar_o,
    output logic [W-1:0]     carry_o,
    output logic             done_o
);
    typedef struct packed {
        lmc_state_e       st;
        logic [W-1:0]     scal;
        logic [W-1:0]     car;
        logic [W-1:0]     lo;
        logic [W-1:0]     hi;
        logic [CNT_W-1:0] left;
        logic             done;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RST = '{st: ST_IDLE, scal: '0, car: '0, lo: '0,
                                      hi: '0, left: '0, done: 1'b0};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.scal = scalar_i;
                    r_d.car  = carry_in_i;
                    r_d.left = count_i;
                    if (count_i == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_TAKE;
                    end
                end
            end
            ST_TAKE: begin
                if (in_valid_i) begin
                    r_d.lo = prod_lo_i;
                    r_d.hi = prod_hi_i;
                    r_d.st = ST_GIVE;
                end
            end
            ST_GIVE: begin
                if (out_ready_i) begin
                    r_d.car  = r_q.hi;
                    r_d.left = r_q.left - ONE;
                    if (r_q.left == ONE) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_TAKE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= SEQ_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready_o  = (r_q.st == ST_TAKE);
    assign out_valid_o = (r_q.st == ST_GIVE);
    assign out_limb_o  = r_q.lo;
    assign scalar_o    = r_q.scal;
    assign carry_o     = r_q.car;
    assign done_o      = r_q.done;
endmodule

// File: rtl/limb_mac_chain.sv
module limb_mac_chain #(
    parameter int W     = 64,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W-1:0]     scalar_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [W-1:0]     carry_in_i,
    input  logic             in_valid_i,
    input  logic [W-1:0]     in_limb_i,
    output logic             in_ready_o,
    output logic             out_valid_o,
    output logic [W-1:0]     out_limb_o,
    input  logic             out_ready_i,
    output logic [W-1:0]     carry_o,
    output logic             done_o
);
    logic [W-1:0] scalar_q;
    logic [W-1:0] step_lo;
    logic [W-1:0] step_hi;

    lmc_muladd #(.W(W)) u_muladd (
        .mul_a  (in_limb_i),
        .mul_b  (scalar_q),
        .add_c  (carry_o),
        .res_lo (step_lo),
        .res_hi (step_hi)
    );

    lmc_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .scalar_i    (scalar_i),
        .count_i     (count_i),
        .carry_in_i  (carry_in_i),
        .in_valid_i  (in_valid_i),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o),
        .out_ready_i (out_ready_i),
        .prod_lo_i   (step_lo),
        .prod_hi_i   (step_hi),
        .out_limb_o  (out_limb_o),
        .scalar_o    (scalar_q),
        .carry_o     (carry_o),
        .done_o      (done_o)
    );
endmodule

// File: rtl/lmc_chain_chk.sv
module lmc_chain_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid_i,
    input logic [W-1:0] in_limb_i,
    input logic         in_ready_o,
    input logic         out_valid_o,
    input logic [W-1:0] out_limb_o,
    input logic         out_ready_i,
    input logic [W-1:0] carry_o,
    input logic         done_o,
    input logic [W-1:0] scalar_q
);
    logic [2*W-1:0] ref_sum;
    logic [W-1:0]   ref_hi_q;

    assign ref_sum = {{W{1'b0}}, in_limb_i} * {{W{1'b0}}, scalar_q} + {{W{1'b0}}, carry_o};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_hi_q <= '0;
        end else if (in_ready_o && in_valid_i) begin
            ref_hi_q <= ref_sum[2*W-1:W];
        end
    end

    assert_step_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && in_valid_i) |=> (out_valid_o && out_limb_o == $past(ref_sum[W-1:0])));

    assert_carry_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i) |=> (carry_o == $past(ref_hi_q)));

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_limb_o)));

    assert_carry_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid_o && !out_ready_i) || in_ready_o) |=> $stable(carry_o));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o || out_valid_o) |=> $stable(scalar_q));

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready_o && out_valid_o));
endmodule

bind limb_mac_chain lmc_chain_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_limb_i   (in_limb_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_limb_o  (out_limb_o),
    .out_ready_i (out_ready_i),
    .carry_o     (carry_o),
    .done_o      (done_o),
    .scalar_q    (scalar_q)
);

// File: tb/test_limb_mac_chain.sv
module test_limb_mac_chain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] scalar_i = '0;
    logic [7:0]  count_i = '0;
    logic [63:0] carry_in_i = '0;
    logic        in_valid_i = 1'b0;
    logic [63:0] in_limb_i = '0;
    logic        in_ready_o;
    logic        out_valid_o;
    logic [63:0] out_limb_o;
    logic        out_ready_i = 1'b0;
    logic [63:0] carry_o;
    logic        done_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    limb_mac_chain i_limb_mac_chain (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .scalar_i(scalar_i),
        .count_i(count_i), .carry_in_i(carry_in_i), .in_valid_i(in_valid_i),
        .in_limb_i(in_limb_i), .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
        .out_limb_o(out_limb_o), .out_ready_i(out_ready_i), .carry_o(carry_o),
        .done_o(done_o)
    );

    localparam int NV = 4;
    localparam logic [63:0] TV_SCAL [NV] = '{64'd3, 64'hFFFF_FFFF_FFFF_FFFF,
                                            64'd0, 64'hDEAD_BEEF_0123_4567};
    localparam logic [63:0] TV_CIN [NV] = '{64'd0, 64'hFFFF_FFFF_FFFF_FFFF,
                                           64'h1234, 64'd9};
    localparam int TV_N [NV] = '{4, 4, 3, 1};
    localparam logic [63:0] TV_LIMB [NV][4] = '{
        '{64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 64'd1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
          64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{64'hAAAA_5555_0F0F_F0F0, 64'h1, 64'h8000_0000_0000_0000, 64'd0},
        '{64'hFEDC_BA98_7654_3210, 64'd0, 64'd0, 64'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one run; model: {hi,lo} = limb*scalar + carry, carry <= hi
    task automatic run_chain(input logic [63:0] sc, input logic [63:0] cin, input int n,
                             input logic [63:0] lv [4], input int stall, input bit poke,
                             output logic [63:0] fin);
        logic [63:0]  c;
        logic [127:0] s;
        int           st;
        c = cin;
        @(negedge clk);
        start_i = 1'b1; scalar_i = sc; count_i = 8'(n); carry_in_i = cin;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid_i = 1'b1; in_limb_i = lv[i];
            while (!in_ready_o) @(negedge clk);
            @(negedge clk);
            in_valid_i = 1'b0; in_limb_i = '0;
            s = {64'd0, lv[i]} * {64'd0, sc} + {64'd0, c};
            chk("R1 out_limb", out_limb_o, s[63:0]);
            st = (poke && i == 0 && stall < 2) ? 2 : stall;
            for (int k = 0; k < st; k++) begin
                if (poke && i == 0 && k == 0) begin
                    start_i = 1'b1; scalar_i = 64'h5; count_i = 8'd1; carry_in_i = 64'h77;
                end
                @(negedge clk);
                start_i = 1'b0;
                chk("R5 valid held", {63'd0, out_valid_o}, 64'd1);
                chk("R5 limb held", out_limb_o, s[63:0]);
                chk("R6 carry quiet", carry_o, c);
            end
            out_ready_i = 1'b1;
            @(negedge clk);
            out_ready_i = 1'b0;
            c = s[127:64];
            chk("R2 carry chained", carry_o, c);
            if (i == n - 1) chk("R7 done after last", {63'd0, done_o}, 64'd1);
            else            chk("R7 no early done", {63'd0, done_o}, 64'd0);
        end
        @(negedge clk);
        chk("R7 done one cycle", {63'd0, done_o}, 64'd0);
        chk("R4 idle in_ready", {63'd0, in_ready_o}, 64'd0);
        chk("R4 idle out_valid", {63'd0, out_valid_o}, 64'd0);
        fin = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] lv [4];
        logic [63:0] fa, fb, fc;
        repeat (3) @(negedge clk);
        chk("R10 reset in_ready", {63'd0, in_ready_o}, 64'd0);
        chk("R10 reset out_valid", {63'd0, out_valid_o}, 64'd0);
        chk("R10 reset done", {63'd0, done_o}, 64'd0);
        chk("R10 reset carry", carry_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R11 under varied stalls
        for (int v = 0; v < NV; v++) begin
            for (int j = 0; j < 4; j++) lv[j] = TV_LIMB[v][j];
            run_chain(TV_SCAL[v], TV_CIN[v], TV_N[v], lv, v % 3, 1'b0, fa);
            chk("R2 final carry_o", carry_o, fa);
        end

        // R11: all-ones step gives lo 0, hi all ones
        for (int j = 0; j < 4; j++) lv[j] = '1;
        run_chain('1, '1, 1, lv, 0, 1'b0, fa);
        chk("R11 max carry", carry_o, 64'hFFFF_FFFF_FFFF_FFFF);

        // R8: start during a stalled run is ignored
        for (int j = 0; j < 4; j++) lv[j] = TV_LIMB[0][j];
        run_chain(64'h1_0000_0003, 64'd0, 3, lv, 3, 1'b1, fa);
        chk("R8 run kept carry", carry_o, fa);

        // R3: split run resumed from carry_o equals a single run
        for (int j = 0; j < 4; j++) lv[j] = TV_LIMB[2][j] ^ 64'hFFFF_0000_FFFF_0000;
        run_chain(64'hCAFE_F00D_1357_9BDF, 64'd0, 4, lv, 0, 1'b0, fa);
        run_chain(64'hCAFE_F00D_1357_9BDF, 64'd0, 2, lv, 1, 1'b0, fb);
        lv[0] = lv[2]; lv[1] = lv[3];
        run_chain(64'hCAFE_F00D_1357_9BDF, fb, 2, lv, 0, 1'b0, fc);
        chk("R3 resumed carry equals single run", fc, fa);

        // R9: count zero
        @(negedge clk);
        start_i = 1'b1; count_i = 8'd0; carry_in_i = 64'h0BAD_CAFE; scalar_i = 64'd4;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 zero-count done", {63'd0, done_o}, 64'd1);
        chk("R9 zero-count carry", carry_o, 64'h0BAD_CAFE);
        chk("R9 no limb wanted", {63'd0, in_ready_o}, 64'd0);
        @(negedge clk);
        chk("R9 done single", {63'd0, done_o}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule